// File: doc/BRIEF.md
# Victim / Next-Victim Replacement Controller

This block holds the replacement state for every set of a set-associative cache with a parameterised number of ways (4 or 8). Rather than a full recency order, each set remembers only two way pointers: the primary eviction candidate (the victim) and its designated successor (the next victim). Every other way in the set is treated as ordinary and carries no state at all.

On each access the cache presents the set index, whether the lookup hit, which way hit, and the valid bits of that set. The block answers, in the same cycle, with the way a miss should fill. At the next clock edge it updates the two pointers for that set according to the access outcome. Whenever a new next victim is needed, it is drawn pseudo-randomly from the ordinary ways. The random draw comes from an internal linear feedback shift register. Tag comparison, data storage and refill traffic are handled elsewhere.

Top module: `vnv_repl_ctrl`

## Requirements
- R1: Every set always holds two different pointers. After reset, every set has victim = way 0 and next victim = way 1.
- R2: `repl_way` is combinational in the current cycle. If any bit of `line_valid` is 0, it names the lowest-numbered way whose bit is 0. Otherwise it names the victim of the set on `acc_set`.
- R3: On a miss (`acc_vld`=1, `acc_hit`=0) with all ways valid, the old next victim becomes the victim, and a randomly picked way (R8) becomes the next victim.
- R4: On a miss while at least one way of the set is invalid, both pointers of that set are left unchanged.
- R5: On a hit to the victim way, the old next victim becomes the victim, and a randomly picked way (R8) becomes the next victim. The old victim therefore becomes ordinary.
- R6: On a hit to the next-victim way, the victim is unchanged and a randomly picked way (R8) becomes the next victim.
- R7: A hit to any way that is neither victim nor next victim leaves the set's pointers unchanged.
- R8: The random pick lists the ways in ascending order, skipping the current victim and the current next victim. It then takes the entry whose index is `lfsr[7:0] mod (WAYS-2)`, using the register value before the access advances it.
- R9: The random register is 16 bits wide and resets to 0xACE1. On each cycle with `acc_vld`=1, it shifts left by one. The new bit 0 is the XOR of bits 15, 13, 12 and 10.
- R10: With `acc_vld`=0, neither the pointers nor the random register change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised internally |
| acc_vld | input | 1 | An access to the cache is presented this cycle |
| acc_set | input | SET_W | Set index of the access |
| acc_hit | input | 1 | The lookup hit |
| acc_way | input | WAY_W | Way that hit (meaningful when acc_hit=1) |
| line_valid | input | WAYS | Valid bits of the addressed set |
| repl_way | output | WAY_W | Way to fill on a miss |

## Verification
The bench builds two instances side by side: one with 4 ways and 4 sets, and one with 8 ways and 8 sets. With 4 ways there are exactly two ordinary ways, so the modulo-2 pick and the tightest exclusion case are exercised on every draw. With 8 ways, the non-power-of-two modulo 6 and picks that skip pointers in the middle of the order come within reach. A behavioural model of both instances checks `repl_way` on every cycle. The hit way is steered onto the victim, the next victim or an ordinary way, and partially valid sets are mixed in, so that every update rule feeds later victim choices.

// File: rtl/vnv_pkg.sv
package vnv_pkg;

  localparam int          RND_W    = 16;
  localparam logic [15:0] RND_SEED = 16'hACE1;

  // one step of the maximal-length sequence x^16+x^14+x^13+x^11+1
  function automatic logic [RND_W-1:0] rnd_step(input logic [RND_W-1:0] s);
    return {s[RND_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  typedef enum logic [2:0] {
    OP_IDLE,
    OP_MISS_SHIFT,
    OP_MISS_FILL,
    OP_HIT_VIC,
    OP_HIT_NXT,
    OP_HIT_ORD
  } vnv_op_e;

endpackage

// File: rtl/vnv_lfsr.sv
module vnv_lfsr
  import vnv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [RND_W-1:0] rnd
);

  logic [RND_W-1:0] rnd_q;
  logic [RND_W-1:0] rnd_d;

  always_comb begin
    rnd_d = rnd_q;
    if (adv) rnd_d = rnd_step(rnd_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rnd_q <= RND_SEED;
    else        rnd_q <= rnd_d;
  end

  assign rnd = rnd_q;

endmodule

// File: rtl/vnv_pick.sv
module vnv_pick #(
  parameter int WAYS  = 8,
  parameter int WAY_W = $clog2(WAYS)
) (
  input  logic [7:0]       rnd_lo,
  input  logic [WAY_W-1:0] excl_a,
  input  logic [WAY_W-1:0] excl_b,
  output logic [WAY_W-1:0] pick
);

  localparam int NORD = WAYS - 2;

  int unsigned k;
  int unsigned cnt;

  always_comb begin
    k    = 32'(rnd_lo) % 32'(NORD);
    cnt  = 0;
    pick = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (WAY_W'(w) != excl_a && WAY_W'(w) != excl_b) begin
        if (cnt == k) pick = WAY_W'(w);
        cnt = cnt + 1;
      end
    end
  end

endmodule

// File: rtl/vnv_table.sv
module vnv_table #(
  parameter int SETS  = 64,
  parameter int WAY_W = 3,
  parameter int SET_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] rd_set,
  output logic [WAY_W-1:0] rd_vic,
  output logic [WAY_W-1:0] rd_nxt,
  input  logic             wr_en,
  input  logic [SET_W-1:0] wr_set,
  input  logic [WAY_W-1:0] wr_vic,
  input  logic [WAY_W-1:0] wr_nxt
);

  logic [WAY_W-1:0] vic_arr [SETS];
  logic [WAY_W-1:0] nxt_arr [SETS];

  for (genvar g = 0; g < SETS; g++) begin : g_set
    logic             ce;
    logic [WAY_W-1:0] vic_q;
    logic [WAY_W-1:0] nxt_q;

    assign ce = wr_en && (wr_set == SET_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vic_q <= WAY_W'(0);
        nxt_q <= WAY_W'(1);
      end else if (ce) begin
        vic_q <= wr_vic;
        nxt_q <= wr_nxt;
      end
    end

    assign vic_arr[g] = vic_q;
    assign nxt_arr[g] = nxt_q;
  end

  assign rd_vic = vic_arr[rd_set];
  assign rd_nxt = nxt_arr[rd_set];

endmodule

// File: rtl/vnv_repl_ctrl.sv
module vnv_repl_ctrl
  import vnv_pkg::*;
#(
  parameter int WAYS  = 8,
  parameter int SETS  = 64,
  parameter int WAY_W = $clog2(WAYS),
  parameter int SET_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_vld,
  input  logic [SET_W-1:0] acc_set,
  input  logic             acc_hit,
  input  logic [WAY_W-1:0] acc_way,
  input  logic [WAYS-1:0]  line_valid,
  output logic [WAY_W-1:0] repl_way
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [RND_W-1:0] rnd;
  logic [WAY_W-1:0] vic_cur;
  logic [WAY_W-1:0] nxt_cur;
  logic [WAY_W-1:0] rnd_pick;
  logic [WAY_W-1:0] vic_new;
  logic [WAY_W-1:0] nxt_new;
  logic             upd;
  logic             all_valid;
  logic [WAY_W-1:0] first_inv;
  vnv_op_e          op;

  vnv_lfsr u_rnd (
    .clk   (clk),
    .rst_n (rst_int_n),
    .adv   (acc_vld),
    .rnd   (rnd)
  );

  vnv_table #(.SETS(SETS), .WAY_W(WAY_W), .SET_W(SET_W)) u_tab (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .rd_set (acc_set),
    .rd_vic (vic_cur),
    .rd_nxt (nxt_cur),
    .wr_en  (upd),
    .wr_set (acc_set),
    .wr_vic (vic_new),
    .wr_nxt (nxt_new)
  );

  vnv_pick #(.WAYS(WAYS), .WAY_W(WAY_W)) u_pick (
    .rnd_lo (rnd[7:0]),
    .excl_a (vic_cur),
    .excl_b (nxt_cur),
    .pick   (rnd_pick)
  );

  // lowest-numbered invalid way
  always_comb begin
    first_inv = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!line_valid[w]) first_inv = WAY_W'(w);
    end
  end

  assign all_valid = &line_valid;
  assign repl_way  = all_valid ? vic_cur : first_inv;

  // classify the access
  always_comb begin
    op = OP_IDLE;
    if (acc_vld) begin
      if (!acc_hit)                op = all_valid ? OP_MISS_SHIFT : OP_MISS_FILL;
      else if (acc_way == vic_cur) op = OP_HIT_VIC;
      else if (acc_way == nxt_cur) op = OP_HIT_NXT;
      else                         op = OP_HIT_ORD;
    end
  end

  // next pointer pair for the addressed set
  always_comb begin
    vic_new = vic_cur;
    nxt_new = nxt_cur;
    upd     = 1'b0;
    unique case (op)
      OP_MISS_SHIFT, OP_HIT_VIC: begin
        vic_new = nxt_cur;
        nxt_new = rnd_pick;
        upd     = 1'b1;
      end
      OP_HIT_NXT: begin
        nxt_new = rnd_pick;
        upd     = 1'b1;
      end
      default: begin
        upd = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/vnv_repl_chk.sv
module vnv_repl_chk #(
  parameter int WAYS  = 8,
  parameter int WAY_W = $clog2(WAYS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc_vld,
  input logic             acc_hit,
  input logic [WAY_W-1:0] acc_way,
  input logic [WAYS-1:0]  line_valid,
  input logic [WAY_W-1:0] repl_way,
  input logic [WAY_W-1:0] vic_cur,
  input logic [WAY_W-1:0] nxt_cur,
  input logic [WAY_W-1:0] vic_new,
  input logic [WAY_W-1:0] nxt_new
);

  // R1
  pair_distinct_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_vld |-> (vic_cur != nxt_cur));

  // R2
  fill_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && !acc_hit && !(&line_valid)) |-> !line_valid[repl_way]);

  // R3
  miss_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && !acc_hit && (&line_valid)) |->
      (vic_new == nxt_cur && nxt_new != vic_cur && nxt_new != nxt_cur));

  // R4
  fill_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && !acc_hit && !(&line_valid)) |->
      (vic_new == vic_cur && nxt_new == nxt_cur));

  // R5
  vic_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && acc_hit && acc_way == vic_cur) |->
      (vic_new == nxt_cur && nxt_new != vic_cur && nxt_new != nxt_cur));

  // R6
  nxt_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && acc_hit && acc_way == nxt_cur) |->
      (vic_new == vic_cur && nxt_new != nxt_cur && nxt_new != vic_cur));

  // R7
  ord_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && acc_hit && acc_way != vic_cur && acc_way != nxt_cur) |->
      (vic_new == vic_cur && nxt_new == nxt_cur));

endmodule

bind vnv_repl_ctrl vnv_repl_chk #(.WAYS(WAYS), .WAY_W(WAY_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_int_n),
  .acc_vld    (acc_vld),
  .acc_hit    (acc_hit),
  .acc_way    (acc_way),
  .line_valid (line_valid),
  .repl_way   (repl_way),
  .vic_cur    (vic_cur),
  .nxt_cur    (nxt_cur),
  .vic_new    (vic_new),
  .nxt_new    (nxt_new)
);

// File: tb/vnv_repl_ctrl_test.sv
module vnv_repl_ctrl_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  // config 0: 4 ways x 4 sets ; config 1: 8 ways x 8 sets
  logic       a_vld, b_vld;
  logic [1:0] a_set;
  logic [2:0] b_set;
  logic       a_hit, b_hit;
  logic [1:0] a_way;
  logic [2:0] b_way;
  logic [3:0] a_val;
  logic [7:0] b_val;
  logic [1:0] a_repl;
  logic [2:0] b_repl;

  vnv_repl_ctrl #(.WAYS(4), .SETS(4)) uut (
    .clk(clk), .rst_n(rst_n), .acc_vld(a_vld), .acc_set(a_set), .acc_hit(a_hit),
    .acc_way(a_way), .line_valid(a_val), .repl_way(a_repl));

  vnv_repl_ctrl #(.WAYS(8), .SETS(8)) uut8 (
    .clk(clk), .rst_n(rst_n), .acc_vld(b_vld), .acc_set(b_set), .acc_hit(b_hit),
    .acc_way(b_way), .line_valid(b_val), .repl_way(b_repl));

  int n_tests = 0;
  int n_fail  = 0;

  int nways [2] = '{4, 8};
  int nsets [2] = '{4, 8};
  int m_vic [2][8];
  int m_nxt [2][8];
  int m_rnd [2];
  string m_tag [2][8];

  int s_vld [2], s_set [2], s_hit [2], s_way [2], s_val [2];

  function automatic int rnd_next(int l);
    int fb;
    fb = ((l >> 15) ^ (l >> 13) ^ (l >> 12) ^ (l >> 10)) & 1;
    return ((l << 1) & 16'hFFFF) | fb;
  endfunction

  function automatic int m_pick(int c, int v, int nv, int l);
    int k, cnt, r;
    k = (l & 255) % (nways[c] - 2);
    cnt = 0; r = -1;
    for (int w = 0; w < nways[c]; w++) begin
      if (w != v && w != nv) begin
        if (cnt == k) r = w;
        cnt++;
      end
    end
    return r;
  endfunction

  task automatic check(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(int c);
    if (c == 0) begin
      a_vld = s_vld[0][0]; a_set = 2'(s_set[0]); a_hit = s_hit[0][0];
      a_way = 2'(s_way[0]); a_val = 4'(s_val[0]);
    end else begin
      b_vld = s_vld[1][0]; b_set = 3'(s_set[1]); b_hit = s_hit[1][0];
      b_way = 3'(s_way[1]); b_val = 8'(s_val[1]);
    end
  endtask

  // expected replacement way, R2
  task automatic check_repl(int c);
    int full, exp, act;
    full = (1 << nways[c]) - 1;
    if (s_val[c] == full) exp = m_vic[c][s_set[c]];
    else begin
      exp = -1;
      for (int w = nways[c] - 1; w >= 0; w--)
        if (((s_val[c] >> w) & 1) == 0) exp = w;
    end
    act = (c == 0) ? int'(a_repl) : int'(b_repl);
    check($sformatf("R2 cfg%0d set%0d after %s", c, s_set[c], m_tag[c][s_set[c]]), act, exp);
  endtask

  // reference update applied at the coming clock edge
  task automatic model_step(int c);
    int s, v, nv, full;
    if (s_vld[c] == 0) return;   // R10: nothing moves
    s = s_set[c]; v = m_vic[c][s]; nv = m_nxt[c][s];
    full = (1 << nways[c]) - 1;
    if (s_hit[c] == 0) begin
      if (s_val[c] == full) begin
        m_vic[c][s] = nv; m_nxt[c][s] = m_pick(c, v, nv, m_rnd[c]); m_tag[c][s] = "R3/R8";
      end else m_tag[c][s] = "R4";
    end else if (s_way[c] == v) begin
      m_vic[c][s] = nv; m_nxt[c][s] = m_pick(c, v, nv, m_rnd[c]); m_tag[c][s] = "R5/R8";
    end else if (s_way[c] == nv) begin
      m_nxt[c][s] = m_pick(c, v, nv, m_rnd[c]); m_tag[c][s] = "R6/R8";
    end else m_tag[c][s] = "R7";
    m_rnd[c] = rnd_next(m_rnd[c]);   // R9
  endtask

  task automatic randomize_in(int c);
    int full, sel, w;
    full = (1 << nways[c]) - 1;
    s_vld[c] = ($urandom % 10) < 8;
    s_set[c] = $urandom % nsets[c];
    s_hit[c] = $urandom % 2;
    s_val[c] = full;
    s_way[c] = 0;
    if (s_hit[c] != 0) begin
      sel = $urandom % 3;
      if (sel == 0) s_way[c] = m_vic[c][s_set[c]];
      else if (sel == 1) s_way[c] = m_nxt[c][s_set[c]];
      else begin
        w = $urandom % nways[c];
        while (w == m_vic[c][s_set[c]] || w == m_nxt[c][s_set[c]]) w = (w + 1) % nways[c];
        s_way[c] = w;
      end
    end else if (($urandom % 5) == 0) begin
      s_val[c] = full & ~(1 << ($urandom % nways[c])) & ($urandom | (1 << 0));
      if (s_val[c] == full) s_val[c] = full & ~1;
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    for (int c = 0; c < 2; c++) begin
      m_rnd[c] = 16'hACE1;
      for (int s = 0; s < 8; s++) begin
        m_vic[c][s] = 0; m_nxt[c][s] = 1; m_tag[c][s] = "R1 reset";
      end
      s_vld[c] = 0; s_set[c] = 0; s_hit[c] = 0; s_way[c] = 0;
      s_val[c] = (1 << nways[c]) - 1;
      drive(c);
    end
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // reset state on every set, with acc_vld low (R1, R10)
    for (int s = 0; s < 8; s++) begin
      @(negedge clk);
      for (int c = 0; c < 2; c++) begin
        s_set[c] = s % nsets[c]; drive(c);
      end
      #1;
      check($sformatf("R1 cfg0 set%0d", s % 4), int'(a_repl), 0);
      check($sformatf("R1 cfg1 set%0d", s), int'(b_repl), 0);
    end

    // lowest invalid way wins (R2)
    @(negedge clk);
    s_val[0] = 4'b1011; s_val[1] = 8'b1110_0111;
    drive(0); drive(1); #1;
    check("R2 cfg0 lowest invalid", int'(a_repl), 2);
    check("R2 cfg1 lowest invalid", int'(b_repl), 3);

    // victim hit then full-valid lookup shows promoted next victim (R5)
    @(negedge clk);
    for (int c = 0; c < 2; c++) begin
      s_vld[c] = 1; s_set[c] = 0; s_hit[c] = 1; s_way[c] = 0;
      s_val[c] = (1 << nways[c]) - 1; drive(c);
    end
    #1;
    check_repl(0); check_repl(1);
    model_step(0); model_step(1);
    @(negedge clk);
    for (int c = 0; c < 2; c++) begin
      s_vld[c] = 0; drive(c);
    end
    #1;
    check("R5 cfg0 victim after hit", int'(a_repl), 1);
    check("R5 cfg1 victim after hit", int'(b_repl), 1);

    // mixed traffic against the reference model
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      for (int c = 0; c < 2; c++) begin
        randomize_in(c); drive(c);
      end
      #1;
      for (int c = 0; c < 2; c++) begin
        check_repl(c);
        model_step(c);
      end
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule